// File: doc/BRIEF.md
# Masked Byte Substitution Unit with Multiplicative Mask Switching

This unit computes the AES byte substitution of a data byte that only ever arrives XOR-masked. The caller supplies the masked byte, its boolean mask, a nonzero multiplicative mask and that mask's field inverse. Internally the boolean mask is traded for the multiplicative one just before the field inversion. The inversion runs on the multiplicatively masked value, and the result is traded back to a boolean mask before the affine step. The plain byte and its plain inverse are never held in any register.

One field multiplier is shared across a fixed schedule of steps. The inversion is an exponentiation to the power 2^8-2, built from alternating squarings and multiplications. The result leaves with a fresh boolean mask: the linear part of the affine map applied to the input mask. The caller therefore knows how the mask changed without ever seeing the data. A zero data byte cannot be hidden by a multiplicative mask, so it is reported on a flag. A multiplicative mask that is zero, or that does not match its claimed inverse, is reported as an error. Both sides of the unit use a valid/ready handshake.

Top module: `msk_sbox_unit`

## Requirements
- R1: After reset is released, `in_ready` is 1 and `out_valid` is 0.
- R2: With A = `in_masked` XOR `in_mask`, and with no error, `out_data` equals S(A) XOR L(`in_mask`). S is the AES substitution: inverse in GF(2^8) modulo x^8+x^4+x^3+x+1 (0x11B), with 0 mapped to 0, then L, then XOR 0x63. Output bit i of L is the XOR of input bits i, i+4, i+5, i+6 and i+7, all taken modulo 8.
- R3: With no error, `out_mask` equals L(`in_mask`).
- R4: `out_zero` is 1 exactly when A is 0 and no error is reported.
- R5: `out_err` is 1 when `in_ymul` is 0, or when the field product of `in_ymul` and `in_yinv` is not 1. In that case `out_data`, `out_mask` and `out_zero` are all 0.
- R6: An operand set is taken only on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from that edge until the result has been taken, so `in_ready` and `out_valid` are never 1 together.
- R7: While `out_valid` is 1 and `out_ready` is 0, the result and both flags are held unchanged. New operands offered during that time are not taken.
- R8: `out_valid` rises 18 clock edges after the edge that takes the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit idle and able to take operands |
| in_masked | input | 8 | Data byte XOR boolean mask |
| in_mask | input | 8 | Boolean mask of the data byte |
| in_ymul | input | 8 | Multiplicative mask, must be nonzero |
| in_yinv | input | 8 | Field inverse of the multiplicative mask |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 8 | Substituted byte under the new mask |
| out_mask | output | 8 | New boolean mask of `out_data` |
| out_zero | output | 1 | Data byte was zero (multiplicative masking gave no cover) |
| out_err | output | 1 | Multiplicative mask zero or mismatched |

## Verification
A zero data byte and a bad multiplicative mask can both apply to one operand set and resolve in the same schedule step. The bench provokes this with A = 0 together with a zero multiplicative mask, and requires the error to win, with the zero flag and the output byte both 0. A second overlap is a stalled result while a new operand set is being offered. The bench keeps `out_ready` low for several cycles with `in_valid` high and changing data, and requires the held output to stay frozen and `in_ready` to stay low. It then checks that the next operand set is handled normally.

// File: rtl/msk_sbox_pkg.sv
package msk_sbox_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_DONE = 2'd2
   } msk_state_e;

   // schedule: two products to switch masks, one mask check,
   // 2*(dw-2) chain steps, one closing square, two products to switch back
   function automatic int step_last(input int dw);
      return 2 * dw + 1;
   endfunction

endpackage

// File: rtl/msk_gf_mul.sv
module msk_gf_mul #(
   parameter int             DW   = 8,
   parameter logic [DW:0]    POLY = 9'h11B
) (
   input  logic [DW-1:0] op_a,
   input  logic [DW-1:0] op_b,
   output logic [DW-1:0] prod
);

   logic [DW-1:0] shv [DW];
   logic [DW-1:0] part [DW+1];

   assign shv[0]  = op_a;
   assign part[0] = '0;

   for (genvar i = 0; i < DW; i++) begin : g_term
      assign part[i+1] = part[i] ^ (op_b[i] ? shv[i] : '0);
      if (i < DW - 1) begin : g_xt
         assign shv[i+1] = {shv[i][DW-2:0], 1'b0} ^
                           (shv[i][DW-1] ? POLY[DW-1:0] : '0);
      end
   end

   assign prod = part[DW];

endmodule

// File: rtl/msk_lin_map.sv
module msk_lin_map #(
   parameter int            DW  = 8,
   parameter logic [DW-1:0] ROW = 8'hF1
) (
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);

   for (genvar i = 0; i < DW; i++) begin : g_row
      logic [DW-1:0] rv;
      assign rv      = (din >> i) | (din << (DW - i));
      assign dout[i] = ^(ROW & rv);
   end

endmodule

// File: rtl/msk_sbox_seq.sv
module msk_sbox_seq
   import msk_sbox_pkg::*;
#(
   parameter int          DW        = 8,
   parameter logic [DW:0] POLY      = 9'h11B,
   parameter bit          CHECK_INV = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_masked,
   input  logic [DW-1:0] in_mask,
   input  logic [DW-1:0] in_ymul,
   input  logic [DW-1:0] in_yinv,
   input  logic          res_take,
   output logic          res_valid,
   output logic [DW-1:0] res_remask,
   output logic [DW-1:0] res_xmask,
   output logic          res_err,
   output logic          res_zero
);

   localparam int            LAST   = step_last(DW);
   localparam int            SW     = $clog2(LAST + 1);
   localparam logic [SW-1:0] S_MY   = SW'(0);
   localparam logic [SW-1:0] S_XY   = SW'(1);
   localparam logic [SW-1:0] S_CHK  = SW'(2);
   localparam logic [SW-1:0] S_BACK = SW'(LAST - 1);
   localparam logic [SW-1:0] S_FIN  = SW'(LAST);

   msk_state_e    state;
   logic [SW-1:0] step;
   logic [DW-1:0] rm, rx, ry, ryi, acc, sv;
   logic          err_q, zero_q;
   logic [DW-1:0] opa, opb, prod;
   logic          bad;

   msk_gf_mul #(.DW(DW), .POLY(POLY)) u_mul (
      .op_a (opa),
      .op_b (opb),
      .prod (prod)
   );

   // operand selection per schedule step
   always_comb begin
      if (step == S_MY) begin
         opa = rm;  opb = ry;
      end else if (step == S_XY) begin
         opa = rx;  opb = ry;
      end else if (step == S_CHK) begin
         opa = ry;  opb = ryi;
      end else if (step == S_BACK) begin
         opa = rx;  opb = ryi;
      end else if (step == S_FIN) begin
         opa = acc; opb = ry;
      end else if (step[0]) begin
         opa = acc; opb = acc;
      end else begin
         opa = acc; opb = sv;
      end
   end

   if (CHECK_INV) begin : g_chk_full
      assign bad = (ry == '0) || (prod != DW'(1));
   end else begin : g_chk_zero
      assign bad = (ry == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         step   <= '0;
         rm     <= '0;
         rx     <= '0;
         ry     <= '0;
         ryi    <= '0;
         acc    <= '0;
         sv     <= '0;
         err_q  <= 1'b0;
         zero_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (in_valid) begin
                  rm    <= in_masked;
                  rx    <= in_mask;
                  ry    <= in_ymul;
                  ryi   <= in_yinv;
                  step  <= '0;
                  state <= ST_BUSY;
               end
            end
            ST_BUSY: begin
               if (step == S_MY) begin
                  acc <= prod;
               end else if (step == S_XY) begin
                  acc <= acc ^ prod;
                  sv  <= acc ^ prod;
               end else if (step == S_CHK) begin
                  err_q  <= bad;
                  zero_q <= (sv == '0) && !bad;
               end else if (step == S_BACK) begin
                  acc <= acc ^ prod;
               end else begin
                  acc <= prod;
               end
               step <= step + SW'(1);
               if (step == S_FIN) state <= ST_DONE;
            end
            ST_DONE: begin
               if (res_take) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign in_ready   = (state == ST_IDLE);
   assign res_valid  = (state == ST_DONE);
   assign res_remask = acc;
   assign res_xmask  = rx;
   assign res_err    = err_q;
   assign res_zero   = zero_q;

endmodule

// File: rtl/msk_sbox_unit.sv
module msk_sbox_unit #(
   parameter int          DW        = 8,
   parameter logic [DW:0] POLY      = 9'h11B,
   parameter logic [DW-1:0] AFF_ROW = 8'hF1,
   parameter logic [DW-1:0] AFF_C   = 8'h63,
   parameter bit          CHECK_INV = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_masked,
   input  logic [DW-1:0] in_mask,
   input  logic [DW-1:0] in_ymul,
   input  logic [DW-1:0] in_yinv,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data,
   output logic [DW-1:0] out_mask,
   output logic          out_zero,
   output logic          out_err
);

   if (DW < 3 || DW > 16) begin : g_bad_dw
      $error("msk_sbox_unit: DW must lie in 3..16");
   end
   if (!POLY[DW] || !POLY[0]) begin : g_bad_poly
      $error("msk_sbox_unit: POLY needs top and constant terms");
   end

   logic [DW-1:0] remask, xmask, lin_d, lin_m;
   logic          err_w, zero_w;

   msk_sbox_seq #(.DW(DW), .POLY(POLY), .CHECK_INV(CHECK_INV)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_masked  (in_masked),
      .in_mask    (in_mask),
      .in_ymul    (in_ymul),
      .in_yinv    (in_yinv),
      .res_take   (out_ready),
      .res_valid  (out_valid),
      .res_remask (remask),
      .res_xmask  (xmask),
      .res_err    (err_w),
      .res_zero   (zero_w)
   );

   msk_lin_map #(.DW(DW), .ROW(AFF_ROW)) u_lin_data (
      .din  (remask),
      .dout (lin_d)
   );

   msk_lin_map #(.DW(DW), .ROW(AFF_ROW)) u_lin_mask (
      .din  (xmask),
      .dout (lin_m)
   );

   assign out_data = err_w ? '0 : (lin_d ^ AFF_C);
   assign out_mask = err_w ? '0 : lin_m;
   assign out_zero = zero_w;
   assign out_err  = err_w;

endmodule

// File: rtl/msk_sbox_chk.sv
module msk_sbox_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_ready,
   input logic          out_valid,
   input logic          out_ready,
   input logic [DW-1:0] out_data,
   input logic [DW-1:0] out_mask,
   input logic          out_zero,
   input logic          out_err
);

   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));

   p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_data) && $stable(out_mask)
          && $stable(out_zero) && $stable(out_err)));

   p_errclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> (out_data == '0 && out_mask == '0));

   p_zero_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> !out_zero);

endmodule

bind msk_sbox_unit msk_sbox_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_mask  (out_mask),
   .out_zero  (out_zero),
   .out_err   (out_err)
);

// File: tb/msk_sbox_unit_bench.sv
`timescale 1ns/1ps
module msk_sbox_unit_bench;

   localparam int LAT = 18;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       out_ready = 1'b0;
   logic [7:0] in_masked = '0, in_mask = '0, in_ymul = '0, in_yinv = '0;
   logic       in_ready, out_valid, out_zero, out_err;
   logic [7:0] out_data, out_mask;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0] inv_t [256];
   logic [7:0] sub_t [256];

   always #4 clk = ~clk;

   msk_sbox_unit u_msk_sbox_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_masked (in_masked),
      .in_mask   (in_mask),
      .in_ymul   (in_ymul),
      .in_yinv   (in_yinv),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_mask  (out_mask),
      .out_zero  (out_zero),
      .out_err   (out_err)
   );

   function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] x = a, y = b, r = 8'h00;
      for (int k = 0; k < 8; k++) begin
         if (y[0]) r = r ^ x;
         y = y >> 1;
         x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
      end
      return r;
   endfunction

   function automatic logic [7:0] rotl(input logic [7:0] v, input int s);
      return (v << s) | (v >> (8 - s));
   endfunction

   function automatic logic [7:0] lmap(input logic [7:0] v);
      return v ^ rotl(v, 1) ^ rotl(v, 2) ^ rotl(v, 3) ^ rotl(v, 4);
   endfunction

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic run_op(input logic [7:0] a, input logic [7:0] x,
                         input logic [7:0] y, input logic [7:0] yi,
                         input bit exp_err, input int stall);
      int n;
      logic [7:0] ed, em;
      logic ez;
      ed = exp_err ? 8'h00 : (sub_t[a] ^ lmap(x));
      em = exp_err ? 8'h00 : lmap(x);
      ez = (a == 8'h00) && !exp_err;
      @(negedge clk);
      in_valid = 1'b1; in_masked = a ^ x; in_mask = x; in_ymul = y; in_yinv = yi;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk(in_ready == 1'b0, "R6 in_ready low after accept", in_ready, 0);
      n = 0;
      while (!out_valid && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk(n == LAT, "R8 latency", n, LAT);
      chk(out_data == ed, $sformatf("R2 data a=%0h x=%0h y=%0h", a, x, y), out_data, ed);
      chk(out_mask == em, $sformatf("R3 mask x=%0h", x), out_mask, em);
      chk(out_zero == ez, $sformatf("R4 zero flag a=%0h", a), out_zero, ez);
      chk(out_err == exp_err, $sformatf("R5 error y=%0h yi=%0h", y, yi), out_err, exp_err);
      chk(in_ready == 1'b0, "R6 no ready with valid", in_ready, 0);
      for (int k = 0; k < stall; k++) begin
         in_valid = 1'b1; in_masked = in_masked + 8'h1;
         @(negedge clk);
         chk(out_valid == 1'b1, "R7 valid held", out_valid, 1);
         chk(out_data == ed, "R7 data held", out_data, ed);
         chk(out_mask == em, "R7 mask held", out_mask, em);
         chk(in_ready == 1'b0, "R7 new operands not taken", in_ready, 0);
      end
      in_valid = 1'b0;
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      for (int a = 0; a < 256; a++) begin
         inv_t[a] = 8'h00;
         for (int b = 1; b < 256; b++)
            if (a != 0 && fmul(8'(a), 8'(b)) == 8'h01) inv_t[a] = 8'(b);
      end
      for (int a = 0; a < 256; a++)
         sub_t[a] = lmap(inv_t[a]) ^ 8'h63;

      repeat (3) @(negedge clk);
      chk(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
      chk(out_valid == 1'b0, "R1 no valid after reset", out_valid, 0);

      // sweep over every data byte, masks varying
      for (int a = 0; a < 256; a++) begin
         logic [7:0] x, y;
         x = 8'(a * 37 + 11);
         y = 8'((a * 7 + 3) % 255 + 1);
         run_op(8'(a), x, y, inv_t[y], 1'b0, 0);
      end
      // sweep over every nonzero multiplicative mask
      for (int v = 1; v < 256; v++) begin
         logic [7:0] y;
         y = 8'(v);
         run_op(y ^ 8'h5A, 8'(v * 13), y, inv_t[y], 1'b0, 0);
      end
      // R5 bad masks; zero data together with zero mask
      run_op(8'h33, 8'hC4, 8'h00, 8'h00, 1'b1, 0);
      run_op(8'h00, 8'h9E, 8'h00, 8'h00, 1'b1, 0);
      run_op(8'h00, 8'h00, 8'h00, 8'h01, 1'b1, 0);
      run_op(8'h71, 8'h2B, 8'h02, 8'h03, 1'b1, 0);
      run_op(8'h00, 8'h10, 8'h53, 8'h53, 1'b1, 0);
      // R7 stalled result with new operands offered, then normal op
      run_op(8'hA7, 8'h3C, 8'h53, inv_t[8'h53], 1'b0, 6);
      run_op(8'h00, 8'hFF, 8'hE1, inv_t[8'hE1], 1'b0, 4);
      run_op(8'h12, 8'h00, 8'h01, 8'h01, 1'b0, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule